// File: doc/BRIEF.md
# Serial NOR Flash Command Decoder with Octal Opcodes

This block is the front end of a serial NOR flash target. It receives the host's transfer as a stream of bytes, one per `byte_valid` strobe, framed by an active-low chip select. The first byte of each frame is taken as an opcode. The decoder sorts it into a command class and works out how many further bytes belong to the command header: address bytes plus any dummy bytes. Once that many bytes have arrived, it settles into a final state that tells the rest of the target what to do next.

The octal read and octal program opcodes are decoded next to the single, dual and quad forms. The number of address bytes depends on the opcode and on the device's current address mode (`addr4_mode`). Opcodes that carry their own 4-byte addressing always collect four address bytes, and one padding byte more while the device sits in 3-byte mode. The dummy count for the fast-read family comes from a configuration value (`dummy_cfg`). The memory array, pin-level octal and DDR timing, and erase timing are handled elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and whenever `cs_n` is high, the decoder reports state IDLE (code 0), class NONE (code 0) and address 0.
- R2: The first accepted byte of a frame picks the class. READ (code 1) covers 03,13,0B,0C,3B,3C,6B,6C,BB,BC,EB,EC,9D,FC,8B,8C,7C,CB,CC,FD. PROGRAM (code 2) covers 02,12,32,34,82,84. ERASE (code 3) covers 20,21,52,5C,D8,DC. REGISTER (code 4) covers 04,05,06,35,70,9F,B7,E9. While header bytes are still owed, the state is COLLECT (code 1).
- R3: Opcodes 03,0B,3B,6B,BB,EB,9D,8B,CB,02,32,82,20,52,D8 collect 3 address bytes when `addr4_mode` is 0 and 4 when it is 1.
- R4: Opcodes 13,0C,3C,6C,BC,EC,FC,CC,12,34,84,21,5C,DC collect 4 address bytes when `addr4_mode` is 1 and 5 when it is 0. The first of those 5 bytes is padding.
- R5: Opcodes 8C and 7C collect exactly 4 bytes with no dummy bytes, and FD collects exactly 4 address bytes, whatever the address mode.
- R6: Opcodes 0B,0C,3B,3C,6B,6C,BB,BC,9D,FC,8B,CB,CC,FD add `dummy_cfg` dummy bytes after the address. Opcodes 03,13, the program opcodes and the erase opcodes add none.
- R7: The quad I/O reads EB and EC add exactly 5 dummy bytes, whatever the value of `dummy_cfg`.
- R8: On the clock edge that accepts the last header byte, the state becomes READ (2), PROGRAM (3) or ERASE (4) to match the class. A REGISTER opcode moves to state REG (5) directly from the opcode byte.
- R9: `cmd_addr` holds the address bytes packed MSB first, with the last address byte in bits 7:0. A 3-byte address leaves bits 31:24 at zero. Padding bytes and dummy bytes never enter the address.
- R10: `cs_n` high at any clock edge aborts the command. On the next cycle the decoder shows IDLE, class NONE and address 0, and it decodes the next frame from its first byte.
- R11: An opcode outside the R2 lists gives state SKIP (6) with class NONE. Later bytes in the same frame change neither state nor address.
- R12: Bytes that arrive after the final state is reached change neither state, class nor address until `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Frame select, active low |
| byte_valid | input | 1 | A byte is presented on `byte_data` this cycle |
| byte_data | input | 8 | Received byte |
| addr4_mode | input | 1 | Device address mode: 1 = 4-byte, 0 = 3-byte |
| dummy_cfg | input | DUMMY_W (4) | Configured dummy byte count for fast reads |
| cmd_class | output | 3 | Decoded command class |
| dec_state | output | 3 | Decoder state |
| cmd_addr | output | 32 | Assembled address |

## Verification
All 256 opcode values are swept under both address modes and two dummy settings. For each combination the bench predicts the class, the number of address bytes, the number of dummy bytes and the final state. Comparing the two address modes separates mode-following opcodes from those with their own 4-byte addressing and from the fixed-length octal ones. Comparing the two dummy settings separates opcodes that take configured dummies from the quad I/O reads with a fixed five and from the reads and programs with none. Each byte of a transaction carries a distinct value, so the packed address shows whether the padding and dummy bytes were kept out of it. A frame aborted partway and then followed by a clean frame shows that no count or address survives the abort.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLLECT = 3'd1,
    ST_READ    = 3'd2,
    ST_PROG    = 3'd3,
    ST_ERASE   = 3'd4,
    ST_REG     = 3'd5,
    ST_SKIP    = 3'd6
  } dec_state_e;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_READ  = 3'd1,
    CL_PROG  = 3'd2,
    CL_ERASE = 3'd3,
    CL_REG   = 3'd4
  } cmd_class_e;

  // How the address length is chosen
  typedef enum logic [1:0] {
    AK_NONE  = 2'd0,  // no address
    AK_MODE  = 2'd1,  // follows the device address mode
    AK_FOURX = 2'd2,  // own 4-byte form, padded in 3-byte mode
    AK_FOUR  = 2'd3   // always exactly four
  } addr_kind_e;

  typedef enum logic [1:0] {
    DK_NONE = 2'd0,
    DK_CFG  = 2'd1,
    DK_FIVE = 2'd2
  } dum_kind_e;

  typedef struct packed {
    logic       known;
    cmd_class_e cls;
    addr_kind_e ak;
    dum_kind_e  dk;
  } op_info_t;

  function automatic op_info_t mk(input cmd_class_e c, input addr_kind_e a, input dum_kind_e d);
    op_info_t r;
    r.known = 1'b1;
    r.cls   = c;
    r.ak    = a;
    r.dk    = d;
    return r;
  endfunction

  function automatic op_info_t lookup_op(input logic [7:0] op);
    op_info_t r;
    r = '{known: 1'b0, cls: CL_NONE, ak: AK_NONE, dk: DK_NONE};
    case (op)
      8'h03:                      r = mk(CL_READ, AK_MODE,  DK_NONE);
      8'h13:                      r = mk(CL_READ, AK_FOURX, DK_NONE);
      8'h0B, 8'h3B, 8'h6B, 8'hBB,
      8'h9D, 8'h8B, 8'hCB:        r = mk(CL_READ, AK_MODE,  DK_CFG);
      8'h0C, 8'h3C, 8'h6C, 8'hBC,
      8'hFC, 8'hCC:               r = mk(CL_READ, AK_FOURX, DK_CFG);
      8'hEB:                      r = mk(CL_READ, AK_MODE,  DK_FIVE);
      8'hEC:                      r = mk(CL_READ, AK_FOURX, DK_FIVE);
      8'h8C, 8'h7C:               r = mk(CL_READ, AK_FOUR,  DK_NONE);
      8'hFD:                      r = mk(CL_READ, AK_FOUR,  DK_CFG);
      8'h02, 8'h32, 8'h82:        r = mk(CL_PROG, AK_MODE,  DK_NONE);
      8'h12, 8'h34, 8'h84:        r = mk(CL_PROG, AK_FOURX, DK_NONE);
      8'h20, 8'h52, 8'hD8:        r = mk(CL_ERASE, AK_MODE,  DK_NONE);
      8'h21, 8'h5C, 8'hDC:        r = mk(CL_ERASE, AK_FOURX, DK_NONE);
      8'h04, 8'h05, 8'h06, 8'h35,
      8'h70, 8'h9F, 8'hB7, 8'hE9: r = mk(CL_REG,  AK_NONE,  DK_NONE);
      default:                    r = r;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] addr_bytes(input addr_kind_e ak, input logic mode4);
    case (ak)
      AK_MODE:  return mode4 ? 3'd4 : 3'd3;
      AK_FOURX: return mode4 ? 3'd4 : 3'd5;
      AK_FOUR:  return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic dec_state_e final_state(input cmd_class_e c);
    case (c)
      CL_READ:  return ST_READ;
      CL_PROG:  return ST_PROG;
      CL_ERASE: return ST_ERASE;
      CL_REG:   return ST_REG;
      default:  return ST_SKIP;
    endcase
  endfunction

endpackage

// File: rtl/fdec_classify.sv
module fdec_classify
  import fdec_pkg::*;
#(
  parameter int DUMMY_W = 4,
  parameter int CNT_W   = 5
) (
  input  logic [7:0]         opcode,
  input  logic               mode4,
  input  logic [DUMMY_W-1:0] dummy_cfg,
  output logic               known,
  output cmd_class_e         cls,
  output logic [2:0]         alen,
  output logic [CNT_W-1:0]   need
);
  localparam int FIXED_DUMMY = 5;

  op_info_t            info;
  logic [CNT_W-1:0]    dum;

  always_comb begin
    info  = lookup_op(opcode);
    known = info.known;
    cls   = info.cls;
    alen  = addr_bytes(info.ak, mode4);
    case (info.dk)
      DK_CFG:  dum = CNT_W'(dummy_cfg);
      DK_FIVE: dum = CNT_W'(FIXED_DUMMY);
      default: dum = '0;
    endcase
    need = CNT_W'(alen) + dum;
  end
endmodule

// File: rtl/fdec_counter.sv
module fdec_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] need,
  input  logic [2:0]       alen,
  output logic [CNT_W-1:0] cnt,
  output logic             in_addr,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign in_addr = (cnt < CNT_W'(alen));
  assign last    = inc && ((cnt + 1'b1) == need);
endmodule

// File: rtl/fdec_addr_shift.sv
module fdec_addr_shift #(
  parameter int ADDR_BYTES = 4,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] addr
);
  logic [7:0] lane [ADDR_BYTES];

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
    logic [7:0] src;
    if (i == 0) begin : g_head
      assign src = din;
    end else begin : g_tail
      assign src = lane[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane[i] <= '0;
      else if (clr)   lane[i] <= '0;
      else if (shift) lane[i] <= src;
    end
    assign addr[8*i +: 8] = lane[i];
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fdec_pkg::*;
#(
  parameter int DUMMY_W    = 4,
  parameter int ADDR_BYTES = 4,
  localparam int MAX_HDR   = ADDR_BYTES + 1 + (1 << DUMMY_W) + 5,
  localparam int CNT_W     = $clog2(MAX_HDR + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  input  logic                    addr4_mode,
  input  logic [DUMMY_W-1:0]      dummy_cfg,
  output logic [2:0]              cmd_class,
  output logic [2:0]              dec_state,
  output logic [8*ADDR_BYTES-1:0] cmd_addr
);
  dec_state_e       state_q, state_d;
  cmd_class_e       cls_q, cls_d;
  logic [CNT_W-1:0] need_q, need_d;
  logic [2:0]       alen_q, alen_d;

  logic             op_known;
  cmd_class_e       op_cls;
  logic [2:0]       op_alen;
  logic [CNT_W-1:0] op_need;

  logic             accept;
  logic             col_inc, col_clr, col_in_addr, col_last;
  logic [CNT_W-1:0] col_cnt;
  logic             a_shift;

  // named events for the checker
  logic             done_evt;
  logic             drop_evt;

  fdec_classify #(.DUMMY_W(DUMMY_W), .CNT_W(CNT_W)) u_cls (
    .opcode    (byte_data),
    .mode4     (addr4_mode),
    .dummy_cfg (dummy_cfg),
    .known     (op_known),
    .cls       (op_cls),
    .alen      (op_alen),
    .need      (op_need)
  );

  assign accept  = byte_valid && !cs_n;
  assign col_inc = accept && (state_q == ST_COLLECT);
  assign col_clr = cs_n || (state_q == ST_IDLE);
  assign a_shift = col_inc && col_in_addr;

  fdec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (col_clr),
    .inc     (col_inc),
    .need    (need_q),
    .alen    (alen_q),
    .cnt     (col_cnt),
    .in_addr (col_in_addr),
    .last    (col_last)
  );

  fdec_addr_shift #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cs_n),
    .shift (a_shift),
    .din   (byte_data),
    .addr  (cmd_addr)
  );

  assign done_evt = col_last;
  assign drop_evt = cs_n && (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    cls_d   = cls_q;
    need_d  = need_q;
    alen_d  = alen_q;
    if (cs_n) begin
      state_d = ST_IDLE;
      cls_d   = CL_NONE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (byte_valid) begin
            if (!op_known) begin
              state_d = ST_SKIP;
            end else begin
              cls_d  = op_cls;
              need_d = op_need;
              alen_d = op_alen;
              state_d = (op_need == '0) ? final_state(op_cls) : ST_COLLECT;
            end
          end
        end
        ST_COLLECT: begin
          if (col_last) state_d = final_state(cls_q);
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cls_q   <= CL_NONE;
      need_q  <= '0;
      alen_q  <= '0;
    end else begin
      state_q <= state_d;
      cls_q   <= cls_d;
      need_q  <= need_d;
      alen_q  <= alen_d;
    end
  end

  assign cmd_class = cls_q;
  assign dec_state = state_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import fdec_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic [2:0]        dec_state,
  input logic [2:0]        cmd_class,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CNT_W-1:0]  col_cnt,
  input logic [CNT_W-1:0]  need_q,
  input logic              done_evt,
  input logic              drop_evt
);
  p_idle_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_state == ST_IDLE) |-> (cmd_class == CL_NONE && cmd_addr == '0));

  p_collect_has_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_state == ST_COLLECT) |-> (cmd_class != CL_NONE));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_state == ST_COLLECT) |-> (col_cnt < need_q));

  p_done_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (dec_state != ST_COLLECT && dec_state != ST_IDLE && dec_state != ST_SKIP));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || drop_evt) |=> (dec_state == ST_IDLE && cmd_class == CL_NONE));

  p_skip_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_state == ST_SKIP && !cs_n) |=> (dec_state == ST_SKIP && $stable(cmd_addr)));

  p_final_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_state inside {ST_READ, ST_PROG, ST_ERASE, ST_REG}) && !cs_n)
      |=> ($stable(dec_state) && $stable(cmd_class) && $stable(cmd_addr)));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.CNT_W(CNT_W), .ADDR_W(8*ADDR_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .dec_state (dec_state),
  .cmd_class (cmd_class),
  .cmd_addr  (cmd_addr),
  .col_cnt   (col_cnt),
  .need_q    (need_q),
  .done_evt  (done_evt),
  .drop_evt  (drop_evt)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        addr4_mode = 1'b0;
  logic [3:0]  dummy_cfg = '0;
  logic [2:0]  cmd_class;
  logic [2:0]  dec_state;
  logic [31:0] cmd_addr;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
    .byte_data(byte_data), .addr4_mode(addr4_mode), .dummy_cfg(dummy_cfg),
    .cmd_class(cmd_class), .dec_state(dec_state), .cmd_addr(cmd_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // Expectation from the requirement lists: {known, class, addr bytes, dummy bytes}
  task automatic expect_op(input logic [7:0] op, input bit m4, input int dcfg,
                           output bit known, output int cls, output int nadr, output int ndum);
    int mode_len;
    int own4_len;
    mode_len = m4 ? 4 : 3;
    own4_len = m4 ? 4 : 5;
    known = 1; cls = 0; nadr = 0; ndum = 0;
    if (op inside {8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h9D, 8'h8B, 8'hCB}) begin
      cls = 1; nadr = mode_len;
    end else if (op inside {8'h13, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC, 8'hFC, 8'hCC}) begin
      cls = 1; nadr = own4_len;
    end else if (op inside {8'h8C, 8'h7C, 8'hFD}) begin
      cls = 1; nadr = 4;
    end else if (op inside {8'h02, 8'h32, 8'h82}) begin
      cls = 2; nadr = mode_len;
    end else if (op inside {8'h12, 8'h34, 8'h84}) begin
      cls = 2; nadr = own4_len;
    end else if (op inside {8'h20, 8'h52, 8'hD8}) begin
      cls = 3; nadr = mode_len;
    end else if (op inside {8'h21, 8'h5C, 8'hDC}) begin
      cls = 3; nadr = own4_len;
    end else if (op inside {8'h04, 8'h05, 8'h06, 8'h35, 8'h70, 8'h9F, 8'hB7, 8'hE9}) begin
      cls = 4;
    end else begin
      known = 0;
    end
    if (op inside {8'hEB, 8'hEC}) ndum = 5;
    else if (op inside {8'h0B, 8'h0C, 8'h3B, 8'h3C, 8'h6B, 8'h6C, 8'hBB, 8'hBC,
                        8'h9D, 8'hFC, 8'h8B, 8'hCB, 8'hCC, 8'hFD}) ndum = dcfg;
  endtask

  task automatic run_op(input logic [7:0] op, input bit m4, input int dcfg);
    bit known;
    int cls, nadr, ndum, total, fin;
    logic [31:0] ea;
    logic [2:0]  st0;
    logic [31:0] a0;
    bit seq_ok;
    expect_op(op, m4, dcfg, known, cls, nadr, ndum);
    total = nadr + ndum;
    fin = cls + 1;
    @(negedge clk);
    addr4_mode = m4;
    dummy_cfg  = 4'(dcfg);
    cs_n = 1'b0;
    send(op);
    if (!known) begin
      chk(dec_state == 3'd6 && cmd_class == 3'd0, "R11 unknown opcode skip", {29'd0, dec_state}, 32'd6);
      send(8'hA5); send(8'h3C);
      chk(dec_state == 3'd6 && cmd_addr == 32'd0, "R11 bytes after unknown", cmd_addr, 32'd0);
    end else if (total == 0) begin
      chk(dec_state == 3'd5 && cmd_class == 3'd4, "R8 register opcode", {29'd0, dec_state}, 32'd5);
    end else begin
      chk(dec_state == 3'd1 && cmd_class == 3'(cls), "R2 class while collecting",
          {26'd0, cmd_class, dec_state}, {26'd0, 3'(cls), 3'd1});
      ea = 0;
      seq_ok = 1;
      for (int k = 0; k < total; k++) begin
        logic [7:0] b;
        b = 8'(op + 8'd29 * 8'(k) + 8'd17);
        if (k < nadr) ea = {ea[23:0], b};
        send(b);
        if (k < total - 1 && dec_state != 3'd1) seq_ok = 0;
      end
      chk(seq_ok, "R3 R4 R5 R6 R7 header length", {31'd0, seq_ok}, 32'd1);
      chk(dec_state == 3'(fin), "R8 final state", {29'd0, dec_state}, 32'(fin));
      chk(cmd_addr == ea, "R9 address packing", cmd_addr, ea);
      st0 = dec_state; a0 = cmd_addr;
      send(8'hFF); send(8'h00);
      chk(dec_state == st0 && cmd_addr == a0 && cmd_class == 3'(cls),
          "R12 trailing bytes ignored", cmd_addr, a0);
    end
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(dec_state == 3'd0 && cmd_class == 3'd0 && cmd_addr == 32'd0,
        "R10 R1 idle after deselect", {26'd0, cmd_class, dec_state}, 32'd0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dec_state == 3'd0 && cmd_class == 3'd0 && cmd_addr == 32'd0,
        "R1 reset state", {26'd0, cmd_class, dec_state}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 256; op++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 2; d++)
          run_op(8'(op), m[0], d ? 9 : 0);

    // R10: abort partway through a header, then a clean frame follows
    @(negedge clk);
    addr4_mode = 1'b0; dummy_cfg = 4'd2; cs_n = 1'b0;
    send(8'h0B); send(8'h11); send(8'h22);
    chk(dec_state == 3'd1, "R10 mid-header before abort", {29'd0, dec_state}, 32'd1);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk(dec_state == 3'd0 && cmd_addr == 32'd0, "R10 abort clears", cmd_addr, 32'd0);
    cs_n = 1'b0;
    send(8'h03); send(8'h44); send(8'h55); send(8'h66);
    chk(dec_state == 3'd2 && cmd_addr == 32'h00445566, "R10 R9 fresh frame after abort",
        cmd_addr, 32'h00445566);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule